// File: doc/BRIEF.md
# Butterfly Barrier Synchronization Engine

This engine sits in the network interface of one processing node and carries out a barrier among `NUM_PROCS` cooperating nodes, where `NUM_PROCS` is a power of two. The barrier runs in a single phase made of log2(`NUM_PROCS`) rounds. In each round the node sends one barrier message to a single partner, and it waits for that partner's message for the same round. The partner in a round is the node whose index differs from this node's index in exactly the bit that matches the round number. When every round has finished, the barrier is complete for this node. No master node and no release broadcast are needed.

The core starts a barrier with a one-cycle command pulse. The engine then offers each outbound message on a valid/ready port that carries the destination node index and the round number. Inbound barrier messages arrive as a one-cycle valid pulse tagged with their round number, and the engine always accepts them. A partner that runs ahead can deliver a message for a later round, or even a message that arrives before this node has started. Such a message is held in a per-round pending bit until the engine reaches that round. The done flag rises when the last round finishes and stays high until the next start command.

Top module: `bfly_barrier_engine`

## Requirements
- R1: After reset, `done_o` and `tx_valid_o` are 0.
- R2: In the cycle after `start_i` is sampled high, `tx_valid_o` is 1, `tx_stage_o` is 0 and `done_o` is 0 (for `NUM_PROCS` > 1).
- R3: While round s is being sent, `tx_dest_o` equals `node_id_i` XOR 2^s and `tx_stage_o` equals s. Round s carries the same encoding s on `rx_stage_i`.
- R4: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_dest_o` and `tx_stage_o` hold their values. Only one message is offered per round: after the handshake, `tx_valid_o` is low until the engine advances.
- R5: The engine moves from round s to round s+1 only when it has sent its round-s message and holds the partner's round-s message. It advances in the cycle where the later of the two events occurs.
- R6: An inbound message for a round that has not yet been reached is kept, even when it arrives before `start_i`. It is consumed when the engine gets to that round, so no further inbound message is needed for it.
- R7: `done_o` rises in the cycle after the last round completes. It stays high while `start_i` is low and clears in the cycle after `start_i`.
- R8: Each barrier sends exactly log2(`NUM_PROCS`) outbound messages from this node.
- R9: With `NUM_PROCS` = 1, `done_o` is 1 in the cycle after `start_i` and no message is ever offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | ID_W | Index of this node |
| start_i | input | 1 | Barrier start command, one-cycle pulse |
| tx_valid_o | output | 1 | Outbound barrier message valid |
| tx_ready_i | input | 1 | Outbound message accepted |
| tx_dest_o | output | ID_W | Destination node of the outbound message |
| tx_stage_o | output | STG_W | Round number of the outbound message |
| rx_valid_i | input | 1 | Inbound barrier message strobe |
| rx_stage_i | input | STG_W | Round number of the inbound message |
| done_o | output | 1 | Barrier complete for this node |

## Verification
The bench covers the two orderings within a round. If the partner's message arrives first, a design that advanced on that message alone would skip its own send, so it would drop a message and show the wrong round on `tx_stage_o`. If the send happens first, a design that advanced on the handshake alone would finish without waiting for its partner. All partner messages are also delivered before `start_i`. A design that cleared its pending bits on a new start, or that ignored messages for a future round, would then hang and never raise `done_o`. The bench further checks the destination sequence for several node indices against hand-computed partners, holds back `tx_ready_i` for a few cycles to catch a design that changes or drops an offered message, and runs a one-node instance that must finish without sending anything.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  function automatic int unsigned min1_clog2(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/bfly_partner_sel.sv
module bfly_partner_sel #(
  parameter int unsigned ID_W  = 3,
  parameter int unsigned STG_W = 2
) (
  input  logic [ID_W-1:0]  node_id_i,
  input  logic [STG_W-1:0] stage_i,
  output logic [ID_W-1:0]  dest_o
);
  // flip the single index bit selected by the stage
  for (genvar b = 0; b < ID_W; b++) begin : g_bit
    assign dest_o[b] = node_id_i[b] ^ (stage_i == STG_W'(b));
  end
endmodule

// File: rtl/bfly_pending.sv
module bfly_pending #(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned STG_W      = 2,
  parameter int unsigned PEND_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [STG_W-1:0] rx_stage_i,
  input  logic [STG_W-1:0] cur_stage_i,
  input  logic             consume_i,
  output logic             have_msg_o
);
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] hit;

  for (genvar k = 0; k < PEND_W; k++) begin : g_slot
    logic set_k, clr_k;
    assign set_k  = rx_valid_i && (rx_stage_i == STG_W'(k)) && (k < NUM_STAGES);
    assign clr_k  = consume_i && (cur_stage_i == STG_W'(k));
    assign hit[k] = (cur_stage_i == STG_W'(k)) && (pend_q[k] || set_k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pend_q[k] <= 1'b0;
      else if (clr_k) pend_q[k] <= 1'b0;
      else if (set_k) pend_q[k] <= 1'b1;
    end
  end

  assign have_msg_o = |hit;
endmodule

// File: rtl/bfly_stage_ctrl.sv
module bfly_stage_ctrl #(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned STG_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tx_fire_i,
  input  logic             have_msg_i,
  output logic             tx_req_o,
  output logic             consume_o,
  output logic [STG_W-1:0] stage_o,
  output logic             done_o
);
  localparam int unsigned LAST = (NUM_STAGES > 0) ? NUM_STAGES - 1 : 0;

  logic             busy_q, sent_q, done_q;
  logic [STG_W-1:0] stage_q;
  logic             adv;

  assign tx_req_o  = busy_q && !sent_q;
  assign adv       = busy_q && (sent_q || tx_fire_i) && have_msg_i;
  assign consume_o = adv;
  assign stage_o   = stage_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sent_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
    end else if (start_i) begin
      busy_q  <= (NUM_STAGES > 0);
      sent_q  <= 1'b0;
      done_q  <= (NUM_STAGES == 0);
      stage_q <= '0;
    end else if (adv) begin
      sent_q <= 1'b0;
      if (stage_q == STG_W'(LAST)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        stage_q <= stage_q + 1'b1;
      end
    end else if (tx_fire_i) begin
      sent_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bfly_barrier_engine.sv
module bfly_barrier_engine #(
  parameter int unsigned NUM_PROCS  = 8,
  parameter int unsigned NUM_STAGES = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 0,
  parameter int unsigned ID_W       = bfly_pkg::min1_clog2(NUM_PROCS),
  parameter int unsigned STG_W      = bfly_pkg::min1_clog2(NUM_STAGES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  node_id_i,
  input  logic             start_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [ID_W-1:0]  tx_dest_o,
  output logic [STG_W-1:0] tx_stage_o,
  input  logic             rx_valid_i,
  input  logic [STG_W-1:0] rx_stage_i,
  output logic             done_o
);
  localparam int unsigned PEND_W = (NUM_STAGES > 0) ? NUM_STAGES : 1;

  logic             tx_req, tx_fire, have_msg, consume;
  logic [STG_W-1:0] stage;

  assign tx_fire    = tx_req && tx_ready_i;
  assign tx_valid_o = tx_req;
  assign tx_stage_o = stage;

  bfly_stage_ctrl #(.NUM_STAGES(NUM_STAGES), .STG_W(STG_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tx_fire_i  (tx_fire),
    .have_msg_i (have_msg),
    .tx_req_o   (tx_req),
    .consume_o  (consume),
    .stage_o    (stage),
    .done_o     (done_o)
  );

  bfly_pending #(.NUM_STAGES(NUM_STAGES), .STG_W(STG_W), .PEND_W(PEND_W)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_stage_i  (rx_stage_i),
    .cur_stage_i (stage),
    .consume_i   (consume),
    .have_msg_o  (have_msg)
  );

  bfly_partner_sel #(.ID_W(ID_W), .STG_W(STG_W)) u_partner (
    .node_id_i (node_id_i),
    .stage_i   (stage),
    .dest_o    (tx_dest_o)
  );
endmodule

// File: rtl/bfly_barrier_chk.sv
module bfly_barrier_chk #(
  parameter int unsigned NUM_STAGES = 3,
  parameter int unsigned ID_W       = 3,
  parameter int unsigned STG_W      = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ID_W-1:0]  node_id_i,
  input logic             start_i,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic [ID_W-1:0]  tx_dest_o,
  input logic [STG_W-1:0] tx_stage_o,
  input logic             done_o
);
  a_r4_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !start_i |=>
      tx_valid_o && $stable(tx_dest_o) && $stable(tx_stage_o));

  a_r3_one_bit_partner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $countones(tx_dest_o ^ node_id_i) == 1);

  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  a_r7_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (NUM_STAGES > 0) |=> !done_o);

  a_r9_idle_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_valid_o);

  a_r2_start_offers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (NUM_STAGES > 0) |=> tx_valid_o && tx_stage_o == '0);
endmodule

bind bfly_barrier_engine bfly_barrier_chk #(
  .NUM_STAGES(NUM_STAGES), .ID_W(ID_W), .STG_W(STG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .node_id_i  (node_id_i),
  .start_i    (start_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_dest_o  (tx_dest_o),
  .tx_stage_o (tx_stage_o),
  .done_o     (done_o)
);

// File: tb/bfly_barrier_engine_tb_top.sv
module bfly_barrier_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] node_id;
  logic       start, tx_ready, rx_valid;
  logic [1:0] rx_stage;
  logic       tx_valid, done;
  logic [2:0] tx_dest;
  logic [1:0] tx_stage;

  bfly_barrier_engine #(.NUM_PROCS(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(node_id), .start_i(start),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_dest_o(tx_dest),
    .tx_stage_o(tx_stage), .rx_valid_i(rx_valid), .rx_stage_i(rx_stage),
    .done_o(done)
  );

  logic       start1, tx_valid1, done1;
  logic [0:0] tx_dest1, tx_stage1;

  bfly_barrier_engine #(.NUM_PROCS(1)) dut1_i (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(1'b0), .start_i(start1),
    .tx_valid_o(tx_valid1), .tx_ready_i(1'b1), .tx_dest_o(tx_dest1),
    .tx_stage_o(tx_stage1), .rx_valid_i(1'b0), .rx_stage_i(1'b0),
    .done_o(done1)
  );

  int checks = 0, fails = 0, msg_cnt = 0;
  always @(posedge clk) if (tx_valid && tx_ready) msg_cnt <= msg_cnt + 1;

  // {id, ready_latency, early, dest0, dest1, dest2}
  localparam logic [14:0] VEC [6] = '{
    {3'd0, 2'd0, 1'b0, 3'd1, 3'd2, 3'd4},
    {3'd5, 2'd2, 1'b0, 3'd4, 3'd7, 3'd1},
    {3'd6, 2'd1, 1'b1, 3'd7, 3'd4, 3'd2},
    {3'd3, 2'd0, 1'b1, 3'd2, 3'd1, 3'd7},
    {3'd7, 2'd3, 1'b0, 3'd6, 3'd5, 3'd3},
    {3'd4, 2'd0, 1'b0, 3'd5, 3'd6, 3'd0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rx_pulse(input int s);
    rx_valid = 1'b1; rx_stage = 2'(s);
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic send_stage(input int s, input logic [2:0] dest, input int lat);
    for (int w = 0; w < 10 && !tx_valid; w++) tick();
    chk(tx_valid, "R2 offer present", int'(tx_valid), 1);
    chk(tx_dest == dest, "R3 partner dest", int'(tx_dest), int'(dest));
    chk(tx_stage == 2'(s), "R3 stage tag", int'(tx_stage), s);
    for (int l = 0; l < lat; l++) begin
      tx_ready = 1'b0;
      tick();
      chk(tx_valid && tx_dest == dest, "R4 held offer", int'(tx_dest), int'(dest));
    end
    tx_ready = 1'b1;
    tick();
    tx_ready = 1'b0;
  endtask

  initial begin
    node_id = '0; start = 0; tx_ready = 0; rx_valid = 0; rx_stage = '0; start1 = 0;
    tick();
    chk(!done && !tx_valid, "R1 reset outputs", int'(done), 0);
    chk(!done1 && !tx_valid1, "R1 reset outputs N1", int'(done1), 0);
    rst_n = 1'b1;
    tick();

    for (int v = 0; v < 6; v++) begin
      logic [2:0] id;
      logic [1:0] lat;
      logic       early;
      logic [2:0] d [3];
      int base;
      {id, lat, early, d[0], d[1], d[2]} = VEC[v];
      node_id = id;
      if (early) for (int s = 0; s < 3; s++) rx_pulse(s); // R6 arrivals before start
      base = msg_cnt;
      start = 1'b1; tick(); start = 1'b0;
      chk(!done && tx_valid && tx_stage == 0, "R2 start state", int'(tx_stage), 0);
      for (int s = 0; s < 3; s++) begin
        send_stage(s, d[s], int'(lat));
        if (!early) begin
          chk(!tx_valid && !done, "R5 waits for partner", int'(tx_valid), 0);
          rx_pulse(s);
        end else if (s < 2) begin
          chk(tx_valid && tx_stage == 2'(s + 1), "R6 pending consumed", int'(tx_stage), s + 1);
        end
      end
      chk(done, "R7 done after last stage", int'(done), 1);
      chk(msg_cnt - base == 3, "R8 message count", msg_cnt - base, 3);
    end

    for (int i = 0; i < 5; i++) tick();
    chk(done, "R7 done holds", int'(done), 1);

    // partner message first, own send later
    node_id = 3'd2;
    start = 1'b1; tick(); start = 1'b0;
    chk(!done, "R7 start clears done", int'(done), 0);
    rx_pulse(0);
    chk(tx_valid && tx_stage == 0 && tx_dest == 3'd3, "R5 no advance without send",
        int'(tx_stage), 0);
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    chk(tx_valid && tx_stage == 1 && tx_dest == 3'd0, "R5 advance on later send",
        int'(tx_stage), 1);
    send_stage(1, 3'd0, 0); rx_pulse(1);
    send_stage(2, 3'd6, 1); rx_pulse(2);
    chk(done, "R7 done after reversed order", int'(done), 1);

    start1 = 1'b1; tick(); start1 = 1'b0;
    chk(done1 && !tx_valid1, "R9 single node done", int'(done1), 1);
    tick();
    chk(done1 && !tx_valid1, "R9 single node no message", int'(tx_valid1), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule